// File: doc/BRIEF.md
# I2C Target Engine with Receive and Transmit FIFOs

This block is the target (slave) side of an I2C link. It watches the SCL and SDA lines through two-flop synchronisers on the system clock and detects START, repeated START and STOP. After each START it shifts in the 7-bit address and the direction bit, and compares the address with a programmable own-address register. On a match it acknowledges and then acts as a receiver or as a transmitter, as the direction bit selects. On a mismatch it stays silent until the next START.

As a receiver it acknowledges every data byte and pushes it into an 8-deep receive FIFO. When that FIFO is full, the byte is dropped, the byte is still acknowledged, and a sticky overflow flag is set. As a transmitter it sends bytes from an 8-deep transmit FIFO for as long as the controller acknowledges them. It interrupts software only when a byte is due and the FIFO is empty. In that case it sets a read-request flag and holds SCL low until software writes a byte.

Software sees the block through a small register port. Offset 0 is the data port. Offset 1 holds the own address. Offset 2 is the raw interrupt status, which is write-1-to-clear. Offset 3 is the interrupt mask. Offset 4 is the masked status. Offset 5 is the status register. Offset 6 is the receive threshold. A read takes effect in the cycle `bus_rd` is high, and a write takes effect at the clock edge.

Top module: `i2c_target_fifo`

## Requirements
- R1: After a START, the block shifts in seven address bits, MSB first, followed by the direction bit (1 = read). If the address equals the own-address register (offset 1, bits 6:0), the block pulls SDA low during the ninth clock. Otherwise it leaves SDA released and ignores every bit until the next START.
- R2: In write direction, every data byte is acknowledged and stored in the receive FIFO. A read of offset 0 returns the oldest stored byte on bits 7:0 and removes it. A read of offset 0 with the FIFO empty returns 0.
- R3: A byte that arrives while the receive FIFO holds 8 entries is discarded. It is still acknowledged, and it sets raw status bit 0.
- R4: Raw status bit 2 is 1 exactly while the receive FIFO level is greater than the threshold register (offset 6, bits 3:0). It follows the level and is not sticky.
- R5: In read direction, bytes are sent MSB first from the transmit FIFO for as long as the controller acknowledges. When the FIFO holds data, no read request is raised.
- R6: If a byte is due in read direction (after the address or after a controller ACK) and the transmit FIFO is empty, raw status bit 5 is set and SCL is held low. The hold lasts until a write to offset 0 supplies a byte, and that byte is then sent.
- R7: A controller NACK after a sent byte ends the transmit phase. SDA stays released, further clocks read as 1, and no transmit entry is consumed until the next START.
- R8: Both a repeated START and a STOP return the block to address matching. A STOP leaves the bus released.
- R9: Raw status bits 0 and 5 stay set until a write to offset 2 with a 1 in that bit position. A 0 in the written value leaves the bit unchanged.
- R10: The masked status (offset 4) equals raw status AND the mask register (offset 3). The `irq` output is 1 exactly when the masked status is non-zero.
- R11: The status register (offset 5) has these fields: bit 0 is 1 while a transfer addressed to the block is in progress; bit 1 is 1 when the transmit FIFO is empty; bit 3 is 1 when the receive FIFO is not empty; bits 7:4 hold the transmit FIFO level.
- R12: After reset, SCL and SDA are released, `irq` is 0, both FIFOs are empty, and the status register reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |

## Verification
A change on a bus line reaches the engine through two synchroniser flops and one edge-detect flop, so the block's SDA or SCL response appears three cycles after the controller's SCL edge. The bench controller leaves half a bit period (20 cycles) between its own edge and any sample of the line, and it waits for SCL to actually rise before counting its high time. This makes a clock stretch visible as a stall rather than a timing error.

Register effects appear one clock edge after a write. Flag updates caused by bus events appear one edge after the event. The bench therefore reads registers at the falling clock edge and only after its own bus task has returned, which is always well past those delays.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX_BYTE,
    ST_RX_ACK,
    ST_TX_LOAD,
    ST_TX_BYTE,
    ST_TX_ACK
  } eng_state_t;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_OWN   = 3'd1;
  localparam logic [2:0] OFS_RAW   = 3'd2;
  localparam logic [2:0] OFS_MASK  = 3'd3;
  localparam logic [2:0] OFS_MSTAT = 3'd4;
  localparam logic [2:0] OFS_STAT  = 3'd5;
  localparam logic [2:0] OFS_THR   = 3'd6;

  localparam int IB_OVF   = 0;
  localparam int IB_RXF   = 2;
  localparam int IB_RDREQ = 5;

  localparam int SB_BUSY = 0;
  localparam int SB_TXE  = 1;
  localparam int SB_RXNE = 3;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/i2ct_fifo.sv
module i2ct_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   wdata,
  input  logic           pop,
  output logic [W-1:0]   rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic           full,
  output logic           empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign rdata   = mem[rptr_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (do_push) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (do_pop)  rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (do_push && !do_pop) cnt_n = cnt_q + LW'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  // Producers must route a byte for a full FIFO elsewhere (overflow flag)
  assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full fifo");

  assert_pop_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("pop from empty fifo");

  assert_level_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (level == $past(level) + LW'(1))) else $error("level did not grow");
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [AW-1:0] own_addr,
  input  logic          rx_full,
  input  logic          tx_empty,
  input  logic [DW-1:0] tx_data,
  output logic          rx_push,
  output logic [DW-1:0] rx_data,
  output logic          rx_ovf,
  output logic          tx_pop,
  output logic          rd_req,
  output logic          busy,
  output logic          scl_low,
  output logic          sda_low
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  eng_state_t    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          rw_q, rw_n, ack_q, ack_n;
  logic          scl_p, sda_p;
  logic          scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = !scl_p && scl_s;
  assign scl_fall = scl_p && !scl_s;
  assign start_c  = scl_p && scl_s && sda_p && !sda_s;
  assign stop_c   = scl_p && scl_s && !sda_p && sda_s;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    rw_n  = rw_q;
    ack_n = ack_q;
    if (start_c) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
    end else if (stop_c) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX_BYTE: begin
          if (scl_rise) begin
            sh_n  = {sh_q[DW-2:0], sda_s};
            cnt_n = cnt_q + CW'(1);
          end else if (scl_fall && cnt_q == LAST) begin
            if (st_q == ST_RX_BYTE) begin
              st_n = ST_RX_ACK;
            end else if (sh_q[DW-1:1] == own_addr) begin
              st_n = ST_ADDR_ACK;
              rw_n = sh_q[0];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall) begin
            if (st_q == ST_ADDR_ACK && rw_q) begin
              st_n = ST_TX_LOAD;
            end else begin
              st_n  = ST_RX_BYTE;
              cnt_n = '0;
            end
          end
        end
        ST_TX_LOAD: begin
          if (!tx_empty) begin
            sh_n  = tx_data;
            cnt_n = '0;
            st_n  = ST_TX_BYTE;
          end
        end
        ST_TX_BYTE: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CW'(1);
          end else if (scl_fall) begin
            if (cnt_q == LAST) st_n = ST_TX_ACK;
            else sh_n = {sh_q[DW-2:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) ack_n = !sda_s;
          else if (scl_fall) st_n = ack_q ? ST_TX_LOAD : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rw_q  <= 1'b0;
      ack_q <= 1'b0;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      rw_q  <= rw_n;
      ack_q <= ack_n;
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  logic byte_done;
  assign byte_done = (st_q == ST_RX_BYTE) && scl_fall && (cnt_q == LAST);
  assign rx_push   = byte_done && !rx_full;
  assign rx_ovf    = byte_done && rx_full;
  assign rx_data   = sh_q;
  assign tx_pop    = (st_q == ST_TX_LOAD) && !tx_empty;
  assign rd_req    = (st_n == ST_TX_LOAD) && (st_q != ST_TX_LOAD) && tx_empty;
  assign busy      = (st_q != ST_IDLE);
  assign scl_low   = (st_q == ST_TX_LOAD);
  assign sda_low   = (st_q == ST_ADDR_ACK) || (st_q == ST_RX_ACK) ||
                     ((st_q == ST_TX_BYTE) && !sh_q[DW-1]);

  // SDA may only move while SCL is low, so the block never fakes START/STOP
  assert_sda_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p) |-> $stable(sda_low)) else $error("sda moved while scl high");

  assert_stretch_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low && !tx_empty) |=> !scl_low) else $error("stretch held with data present");

  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_ACK && scl_fall && !ack_q) |=> (!sda_low && !scl_low && !busy))
    else $error("bus not released after nack");
endmodule

// File: rtl/i2c_target_fifo.sv
module i2c_target_fifo
  import i2ct_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 7,
  parameter logic [6:0] OWN_RST = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic rst_core_n, scl_s, sda_s;

  i2ct_sync #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n));
  i2ct_sync #(.RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_core_n), .d(scl_i), .q(scl_s));
  i2ct_sync #(.RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_core_n), .d(sda_i), .q(sda_s));

  logic [ADDR_W-1:0] own_q, own_n;
  logic [7:0]        mask_q, mask_n;
  logic [LW-1:0]     thr_q, thr_n;
  logic              ovf_q, ovf_n, rq_q, rq_n;

  logic          rx_push, rx_ovf, tx_pop, rd_req, busy;
  logic [DW-1:0] rx_wdata, rx_rdata, tx_rdata;
  logic [LW-1:0] rx_lvl, tx_lvl;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          rx_pop, tx_push;

  assign rx_pop  = bus_rd && (bus_addr == OFS_DATA) && !rx_empty;
  assign tx_push = bus_wr && (bus_addr == OFS_DATA) && !tx_full;

  i2ct_engine #(.AW(ADDR_W), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_core_n), .scl_s(scl_s), .sda_s(sda_s),
    .own_addr(own_q), .rx_full(rx_full), .tx_empty(tx_empty), .tx_data(tx_rdata),
    .rx_push(rx_push), .rx_data(rx_wdata), .rx_ovf(rx_ovf), .tx_pop(tx_pop),
    .rd_req(rd_req), .busy(busy), .scl_low(scl_drive_low), .sda_low(sda_drive_low));

  i2ct_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  i2ct_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  logic       wr_raw;
  logic [7:0] raw, masked, stat;

  assign wr_raw = bus_wr && (bus_addr == OFS_RAW);

  always_comb begin
    own_n  = own_q;
    mask_n = mask_q;
    thr_n  = thr_q;
    if (bus_wr && bus_addr == OFS_OWN)  own_n  = bus_wdata[ADDR_W-1:0];
    if (bus_wr && bus_addr == OFS_MASK) mask_n = bus_wdata;
    if (bus_wr && bus_addr == OFS_THR)  thr_n  = bus_wdata[LW-1:0];
    ovf_n = rx_ovf || (ovf_q && !(wr_raw && bus_wdata[IB_OVF]));
    rq_n  = rd_req || (rq_q && !(wr_raw && bus_wdata[IB_RDREQ]));
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      own_q  <= OWN_RST[ADDR_W-1:0];
      mask_q <= '0;
      thr_q  <= '0;
      ovf_q  <= 1'b0;
      rq_q   <= 1'b0;
    end else begin
      own_q  <= own_n;
      mask_q <= mask_n;
      thr_q  <= thr_n;
      ovf_q  <= ovf_n;
      rq_q   <= rq_n;
    end
  end

  always_comb begin
    raw            = '0;
    raw[IB_OVF]    = ovf_q;
    raw[IB_RXF]    = (rx_lvl > thr_q);
    raw[IB_RDREQ]  = rq_q;
    masked         = raw & mask_q;
    stat           = '0;
    stat[SB_BUSY]  = busy;
    stat[SB_TXE]   = tx_empty;
    stat[SB_RXNE]  = !rx_empty;
    stat[7:4]      = 4'(tx_lvl);
  end

  assign irq = |masked;

  always_comb begin
    unique case (bus_addr)
      OFS_DATA:  bus_rdata = rx_empty ? '0 : 8'(rx_rdata);
      OFS_OWN:   bus_rdata = 8'(own_q);
      OFS_RAW:   bus_rdata = raw;
      OFS_MASK:  bus_rdata = mask_q;
      OFS_MSTAT: bus_rdata = masked;
      OFS_STAT:  bus_rdata = stat;
      OFS_THR:   bus_rdata = 8'(thr_q);
      default:   bus_rdata = '0;
    endcase
  end

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    rx_ovf |=> raw[IB_OVF]) else $error("overflow not recorded");

  assert_rdreq_flag_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_req |=> raw[IB_RDREQ]) else $error("read request not recorded");

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (raw[IB_OVF] && !wr_raw) |=> raw[IB_OVF]) else $error("overflow flag lost");
endmodule

// File: tb/i2c_target_fifo_test.sv
module i2c_target_fifo_test;
  localparam int HALF = 20;

  logic clk, rst_n;
  logic bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic scl_drive_low, sda_drive_low, irq;
  logic m_scl_low, m_sda_low;
  logic scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_drive_low);
  assign sda_line = !(m_sda_low || sda_drive_low);

  i2c_target_fifo uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = !clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  function automatic logic [7:0] exp_raw(input logic ovf, input int lvl, input int thr, input logic rq);
    logic [7:0] r;
    r = '0;
    r[0] = ovf;
    r[2] = (lvl > thr);
    r[5] = rq;
    return r;
  endfunction

  function automatic logic [7:0] exp_stat(input logic bsy, input int txl, input int rxl);
    return {4'(txl), (rxl != 0), 1'b0, (txl == 0), bsy};
  endfunction

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic scl_hi;
    m_scl_low = 1'b0;
    wait (scl_line == 1'b1);
    wait_cyc(HALF);
  endtask

  task automatic scl_lo;
    m_scl_low = 1'b1;
    wait_cyc(6);
  endtask

  task automatic bit_out(input logic b);
    m_sda_low = !b;
    wait_cyc(HALF);
    scl_hi;
    scl_lo;
  endtask

  task automatic bit_in(output logic b);
    m_sda_low = 1'b0;
    wait_cyc(HALF);
    m_scl_low = 1'b0;
    wait (scl_line == 1'b1);
    wait_cyc(HALF / 2);
    b = sda_line;
    wait_cyc(HALF / 2);
    scl_lo;
  endtask

  task automatic m_start;
    m_sda_low = 1'b0;
    wait_cyc(HALF);
    scl_hi;
    m_sda_low = 1'b1;
    wait_cyc(HALF);
    scl_lo;
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1;
    wait_cyc(HALF);
    scl_hi;
    m_sda_low = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(nack);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(nack);
  endtask

  localparam logic [6:0] ME = 7'h3C;

  initial begin
    logic [7:0] v, got;
    logic a;
    logic [7:0] q [0:15];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    m_scl_low = 0; m_sda_low = 0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // R12 reset state
    @(negedge clk);
    chk("R12 scl released", scl_drive_low, 0);
    chk("R12 sda released", sda_drive_low, 0);
    chk("R12 irq", irq, 0);
    reg_rd(3'd5, v); chk("R12 status", v, exp_stat(0, 0, 0));
    reg_rd(3'd2, v); chk("R12 raw", v, 8'h00);

    reg_wr(3'd1, {1'b0, ME});
    reg_wr(3'd6, 8'd3);
    reg_rd(3'd1, v); chk("R1 own address readback", v, {1'b0, ME});

    // R1 mismatch: no ACK, data ignored
    m_start;
    wr_byte(addr_byte(7'h11, 0), a); chk("R1 mismatch nack", a, 1);
    wr_byte(8'h99, a); chk("R1 ignored byte nack", a, 1);
    m_stop;
    reg_rd(3'd5, v); chk("R1 nothing stored", v, exp_stat(0, 0, 0));

    // R2 random write bursts
    for (int r = 0; r < 3; r++) begin
      int n;
      n = 1 + int'($urandom % 4);
      m_start;
      wr_byte(addr_byte(ME, 0), a); chk("R1 match ack", a, 0);
      for (int i = 0; i < n; i++) begin
        q[i] = 8'($urandom);
        wr_byte(q[i], a); chk("R2 data ack", a, 0);
      end
      m_stop;
      reg_rd(3'd5, v); chk("R11 rx not empty", v, exp_stat(0, 0, n));
      for (int i = 0; i < n; i++) begin
        reg_rd(3'd0, got); chk("R2 read order", got, q[i]);
      end
      reg_rd(3'd0, got); chk("R2 empty read zero", got, 8'h00);
    end

    // R4 threshold on receive level
    m_start;
    wr_byte(addr_byte(ME, 0), a);
    for (int i = 0; i < 4; i++) begin
      wr_byte(8'h10 + 8'(i), a);
      reg_rd(3'd2, v); chk("R4 rx level flag", v, exp_raw(0, i + 1, 3, 0));
    end
    reg_rd(3'd5, v); chk("R11 busy mid transfer", v, exp_stat(1, 0, 4));
    m_stop;
    reg_rd(3'd0, got); chk("R2 first of four", got, 8'h10);
    reg_rd(3'd2, v); chk("R4 flag follows level", v, exp_raw(0, 3, 3, 0));
    for (int i = 0; i < 3; i++) reg_rd(3'd0, got);

    // R3 overflow: ten bytes into eight entries
    m_start;
    wr_byte(addr_byte(ME, 0), a);
    for (int i = 0; i < 10; i++) begin
      q[i] = 8'($urandom);
      wr_byte(q[i], a); chk("R3 ack despite full", a, 0);
    end
    m_stop;
    reg_rd(3'd2, v); chk("R3 overflow raw", v, exp_raw(1, 8, 3, 0));

    // R10 masking
    reg_wr(3'd3, 8'h00);
    @(negedge clk); chk("R10 irq masked off", irq, 0);
    reg_rd(3'd4, v); chk("R10 masked status zero", v, 8'h00);
    reg_wr(3'd3, 8'h21);
    reg_rd(3'd4, v); chk("R10 masked status", v, exp_raw(1, 8, 3, 0) & 8'h21);
    @(negedge clk); chk("R10 irq on", irq, 1);

    for (int i = 0; i < 8; i++) begin
      reg_rd(3'd0, got); chk("R3 kept first eight", got, q[i]);
    end
    reg_rd(3'd2, v); chk("R9 ovf sticky after drain", v, exp_raw(1, 0, 3, 0));
    reg_wr(3'd2, 8'h00);
    reg_rd(3'd2, v); chk("R9 write zero keeps", v, exp_raw(1, 0, 3, 0));
    reg_wr(3'd2, 8'h01);
    reg_rd(3'd2, v); chk("R9 write one clears", v, 8'h00);
    @(negedge clk); chk("R10 irq off after clear", irq, 0);

    // R5 transmit from filled FIFO
    for (int i = 0; i < 3; i++) begin
      q[i] = 8'($urandom);
      reg_wr(3'd0, q[i]);
    end
    reg_rd(3'd5, v); chk("R11 tx level", v, exp_stat(0, 3, 0));
    m_start;
    wr_byte(addr_byte(ME, 1), a); chk("R1 read ack", a, 0);
    for (int i = 0; i < 3; i++) begin
      rd_byte(i == 2, got); chk("R5 sent byte", got, q[i]);
    end
    reg_rd(3'd2, v); chk("R5 no read request", v, 8'h00);
    m_stop;
    reg_rd(3'd5, v); chk("R11 tx empty", v, exp_stat(0, 0, 0));

    // R6 empty FIFO stretches
    m_start;
    wr_byte(addr_byte(ME, 1), a);
    fork
      rd_byte(1'b1, got);
      begin
        wait_cyc(150);
        @(negedge clk);
        chk("R6 scl held low", scl_line, 0);
        reg_rd(3'd2, v); chk("R6 read request raw", v, exp_raw(0, 0, 3, 1));
        @(negedge clk); chk("R6 irq", irq, 1);
        reg_wr(3'd0, 8'hA5);
      end
    join
    chk("R6 byte after stretch", got, 8'hA5);
    m_stop;
    reg_wr(3'd2, 8'h20);
    reg_rd(3'd2, v); chk("R9 read request cleared", v, 8'h00);

    // R7 NACK ends transmit
    reg_wr(3'd0, 8'hAA); reg_wr(3'd0, 8'hBB); reg_wr(3'd0, 8'hCC);
    m_start;
    wr_byte(addr_byte(ME, 1), a);
    rd_byte(1'b1, got); chk("R7 first byte", got, 8'hAA);
    wait_cyc(10);
    chk("R7 sda released", sda_line, 1);
    reg_rd(3'd5, v); chk("R7 idle, two left", v, exp_stat(0, 2, 0));
    rd_byte(1'b1, got); chk("R7 extra clocks read ones", got, 8'hFF);
    reg_rd(3'd5, v); chk("R7 nothing consumed", v, exp_stat(0, 2, 0));
    m_stop;

    // R8 repeated START switches direction
    m_start;
    wr_byte(addr_byte(ME, 0), a);
    wr_byte(8'h5A, a); chk("R8 write before rstart", a, 0);
    m_start;
    wr_byte(addr_byte(ME, 1), a); chk("R8 address after rstart", a, 0);
    rd_byte(1'b0, got); chk("R8 read after rstart", got, 8'hBB);
    rd_byte(1'b1, got); chk("R8 second read", got, 8'hCC);
    m_start;
    wr_byte(addr_byte(ME, 0), a); chk("R8 third address", a, 0);
    wr_byte(8'h77, a);
    m_stop;
    chk("R8 bus released after stop", {scl_drive_low, sda_drive_low}, 2'b00);
    reg_rd(3'd0, got); chk("R8 rx first", got, 8'h5A);
    reg_rd(3'd0, got); chk("R8 rx second", got, 8'h77);
    reg_rd(3'd5, v); chk("R8 idle status", v, exp_stat(0, 0, 0));

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(180000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule